// File: doc/BRIEF.md
# I2C Bus Clock Timing Generator

This block paces the clock line of an I2C master. A 4-bit prescaler divides the kernel clock into a time base. The block then walks a low phase and a high phase, each with its own 8-bit count. Within the low phase it raises a one-cycle strobe that tells the data path when to change SDA. That strobe comes after a programmable hold delay. The clock is released only once a programmable setup delay has passed after the strobe.

The bus line is read back through a synchroniser. The high count starts only after the block sees SCL high on the wire. A slave that holds the clock low therefore stretches the period, and a slow rising edge is absorbed the same way. All five timing fields sit in one configuration register. That register accepts writes only while the block is disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: During and immediately after reset, `scl_low_o`, `tick_o` and `sda_update_o` are all 0.
- R2: While a low or high phase runs, `tick_o` pulses once every `presc`+1 kernel cycles, and the first pulse falls on the last cycle of the first interval of the phase.
- R3: When `low`+1 is not smaller than `hold`+`setup`+1, a low phase (`scl_low_o`=1) lasts exactly (`low`+1)*(`presc`+1) cycles.
- R4: After SCL is released, the high count starts only when the synchronised bus level reads 1. With no stretching, the line stays released for SYNC_STAGES+1+(`high`+1)*(`presc`+1) cycles.
- R5: While another device holds the bus line low after release, `scl_low_o` stays 0 and `tick_o` stays 0.
- R6: `sda_update_o` pulses exactly once per low phase, `hold`*(`presc`+1) cycles after the phase starts. It is never asserted outside a low phase.
- R7: When `hold`+`setup`+1 exceeds `low`+1, the low phase is stretched to (`hold`+`setup`+1)*(`presc`+1) cycles. This gives a setup time of `setup`+1 ticks from the SDA strobe to the release.
- R8: A configuration write (`cfg_we`=1) has no effect while `enable`=1. It is captured at the clock edge only while `enable`=0.
- R9: With `run`=0, the block finishes the current high phase and then stays idle with SCL released. Taking `enable` low releases SCL at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 forces idle and opens the configuration register |
| run | input | 1 | Request for continuous SCL cycles |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_presc | input | 4 | Prescaler field; tick period is value+1 cycles |
| cfg_low | input | 8 | Low count; low time is value+1 ticks |
| cfg_high | input | 8 | High count; high time is value+1 ticks |
| cfg_hold | input | 4 | Ticks from SCL low to the SDA strobe |
| cfg_setup | input | 4 | Setup field; value+1 ticks from the SDA strobe to release |
| scl_in | input | 1 | Level of the SCL wire as seen on the bus |
| scl_low_o | output | 1 | 1 pulls SCL low (open-drain drive) |
| sda_update_o | output | 1 | One-cycle strobe: change SDA now |
| tick_o | output | 1 | Prescaled time-base pulse during timed phases |

## Verification
The hardest state to reach is the wait for a high level that never arrives. The block has released SCL, but the wire stays low because a slave holds it. The bench models the wire as the AND of the block's own release and a stretch control. It raises the stretch control while a low phase is running, so that release is immediately overridden. It then checks for a dozen cycles that neither the drive nor the tick moves. After the stretch ends, the per-cycle reference model confirms that the high count starts exactly SYNC_STAGES+1 cycles later. The same model follows a configuration write made while the block is enabled, and a disable that arrives in the middle of a low phase.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
   localparam int unsigned TG_PRESC_W = 4;
   localparam int unsigned TG_LOW_W   = 8;
   localparam int unsigned TG_HIGH_W  = 8;
   localparam int unsigned TG_HOLD_W  = 4;
   localparam int unsigned TG_SETUP_W = 4;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_LOW     = 2'd1,
      PH_WAIT_HI = 2'd2,
      PH_HIGH    = 2'd3
   } phase_e;

   typedef struct packed {
      logic [TG_PRESC_W-1:0] presc;
      logic [TG_LOW_W-1:0]   low_cnt;
      logic [TG_HIGH_W-1:0]  high_cnt;
      logic [TG_HOLD_W-1:0]  hold_dly;
      logic [TG_SETUP_W-1:0] setup_dly;
   } tcfg_t;
endpackage

// File: rtl/i2c_tg_prescale.sv
module i2c_tg_prescale #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active_i,
   input  logic [W-1:0] presc_i,
   output logic         tick_o,
   output logic         zero_o
);
   logic [W-1:0] pcnt;
   logic         at_end;

   assign at_end = (pcnt == presc_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pcnt <= '0;
      else if (!active_i) pcnt <= '0;
      else if (at_end)   pcnt <= '0;
      else               pcnt <= pcnt + 1'b1;
   end

   assign tick_o = active_i && at_end;
   assign zero_o = (pcnt == '0);
endmodule

// File: rtl/i2c_tg_sync.sv
module i2c_tg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= 1'b0;
            else        ff <= d_i;
         end
         assign q_o = ff;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d_i};
         end
         assign q_o = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/i2c_tg_phase.sv
module i2c_tg_phase
   import i2c_tg_pkg::*;
#(
   parameter int unsigned LOW_W   = TG_LOW_W,
   parameter int unsigned HIGH_W  = TG_HIGH_W,
   parameter int unsigned HOLD_W  = TG_HOLD_W,
   parameter int unsigned SETUP_W = TG_SETUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable_i,
   input  logic               run_i,
   input  logic               tick_i,
   input  logic               pzero_i,
   input  logic               scl_hi_i,
   input  logic [LOW_W-1:0]   low_cnt_i,
   input  logic [HIGH_W-1:0]  high_cnt_i,
   input  logic [HOLD_W-1:0]  hold_i,
   input  logic [SETUP_W-1:0] setup_i,
   output phase_e             phase_o,
   output logic               sda_upd_o
);
   localparam int unsigned DLY_W  = ((HOLD_W > SETUP_W) ? HOLD_W : SETUP_W) + 1;
   localparam int unsigned BASE_W = (LOW_W > HIGH_W) ? LOW_W : HIGH_W;
   localparam int unsigned CNT_W  = ((BASE_W > DLY_W) ? BASE_W : DLY_W) + 1;

   phase_e           st;
   logic [CNT_W-1:0] tcnt;
   logic [CNT_W-1:0] tcnt_inc;
   logic [CNT_W-1:0] len_clk;
   logic [CNT_W-1:0] len_dly;
   logic [CNT_W-1:0] low_len;

   always_comb begin
      tcnt_inc = tcnt + 1'b1;
      len_clk  = CNT_W'(low_cnt_i) + 1'b1;
      len_dly  = CNT_W'(hold_i) + CNT_W'(setup_i) + 1'b1;
      low_len  = (len_dly > len_clk) ? len_dly : len_clk;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= PH_IDLE;
         tcnt <= '0;
      end else if (!enable_i) begin
         st   <= PH_IDLE;
         tcnt <= '0;
      end else begin
         case (st)
            PH_IDLE: begin
               if (run_i) begin
                  st   <= PH_LOW;
                  tcnt <= '0;
               end
            end
            PH_LOW: begin
               if (tick_i) begin
                  if (tcnt_inc >= low_len) begin
                     st   <= PH_WAIT_HI;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt_inc;
                  end
               end
            end
            PH_WAIT_HI: begin
               if (scl_hi_i) st <= PH_HIGH;
            end
            PH_HIGH: begin
               if (tick_i) begin
                  if (tcnt == CNT_W'(high_cnt_i)) begin
                     st   <= run_i ? PH_LOW : PH_IDLE;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt_inc;
                  end
               end
            end
            default: begin
               st   <= PH_IDLE;
               tcnt <= '0;
            end
         endcase
      end
   end

   assign phase_o   = st;
   assign sda_upd_o = (st == PH_LOW) && pzero_i && (tcnt == CNT_W'(hold_i));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
   import i2c_tg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  run,
   input  logic                  cfg_we,
   input  logic [TG_PRESC_W-1:0] cfg_presc,
   input  logic [TG_LOW_W-1:0]   cfg_low,
   input  logic [TG_HIGH_W-1:0]  cfg_high,
   input  logic [TG_HOLD_W-1:0]  cfg_hold,
   input  logic [TG_SETUP_W-1:0] cfg_setup,
   input  logic                  scl_in,
   output logic                  scl_low_o,
   output logic                  sda_update_o,
   output logic                  tick_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("i2c_scl_timer: SYNC_STAGES must be at least 2");
      end
      if (TG_PRESC_W < 1 || TG_LOW_W < 1 || TG_HIGH_W < 1) begin : g_bad_width
         $error("i2c_scl_timer: field widths must be non-zero");
      end
   endgenerate

   tcfg_t  cfg_q;
   phase_e phase;
   logic   active;
   logic   tick;
   logic   pzero;
   logic   scl_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we && !enable) begin
         cfg_q.presc     <= cfg_presc;
         cfg_q.low_cnt   <= cfg_low;
         cfg_q.high_cnt  <= cfg_high;
         cfg_q.hold_dly  <= cfg_hold;
         cfg_q.setup_dly <= cfg_setup;
      end
   end

   assign active = (phase == PH_LOW) || (phase == PH_HIGH);

   i2c_tg_prescale #(.W(TG_PRESC_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .presc_i  (cfg_q.presc),
      .tick_o   (tick),
      .zero_o   (pzero)
   );

   i2c_tg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (scl_in),
      .q_o   (scl_hi)
   );

   i2c_tg_phase u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable_i   (enable),
      .run_i      (run),
      .tick_i     (tick),
      .pzero_i    (pzero),
      .scl_hi_i   (scl_hi),
      .low_cnt_i  (cfg_q.low_cnt),
      .high_cnt_i (cfg_q.high_cnt),
      .hold_i     (cfg_q.hold_dly),
      .setup_i    (cfg_q.setup_dly),
      .phase_o    (phase),
      .sda_upd_o  (sda_update_o)
   );

   assign scl_low_o = (phase == PH_LOW);
   assign tick_o    = tick;
endmodule

// File: rtl/i2c_tg_chk.sv
module i2c_tg_chk
   import i2c_tg_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  enable,
   input logic  tick_o,
   input logic  scl_low_o,
   input logic  sda_update_o,
   input tcfg_t cfg_q
);
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable)) |-> $stable(cfg_q)); // R8

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && cfg_q.presc != '0) |=> !tick_o); // R2

   AST_UPD_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      sda_update_o |-> scl_low_o); // R6

   AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      sda_update_o |=> !sda_update_o); // R6

   AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scl_low_o); // R9

   AST_WAIT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_low_o) |=> !scl_low_o); // R5
endmodule

bind i2c_scl_timer i2c_tg_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .tick_o       (tick_o),
   .scl_low_o    (scl_low_o),
   .sda_update_o (sda_update_o),
   .cfg_q        (cfg_q)
);

// File: tb/i2c_scl_timer_bench.sv
module i2c_scl_timer_bench;
   localparam int SYNC = 2;

   logic       clk = 1'b0, rst_n = 1'b0, enable = 1'b0, run = 1'b0;
   logic       cfg_we = 1'b0, stretch = 1'b0;
   logic [3:0] cfg_presc = '0, cfg_hold = '0, cfg_setup = '0;
   logic [7:0] cfg_low = '0, cfg_high = '0;
   logic       scl_low_o, sda_update_o, tick_o;
   wire        scl_bus;

   assign scl_bus = !scl_low_o && !stretch;

   always #10 clk = ~clk;

   i2c_scl_timer #(.SYNC_STAGES(SYNC)) u_i2c_scl_timer (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .cfg_we(cfg_we),
      .cfg_presc(cfg_presc), .cfg_low(cfg_low), .cfg_high(cfg_high),
      .cfg_hold(cfg_hold), .cfg_setup(cfg_setup), .scl_in(scl_bus),
      .scl_low_o(scl_low_o), .sda_update_o(sda_update_o), .tick_o(tick_o)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit done = 0;

   // reference model: 0 idle, 1 low, 2 wait-high, 3 high; m_c = cycles in phase
   int m_st = 0, m_c = 0, m_p = 0, m_l = 0, m_h = 0, m_hd = 0, m_su = 0;
   bit m_sy [SYNC];

   function automatic int low_len();
      int a = m_l + 1;
      int b = m_hd + m_su + 1;
      return (b > a) ? b : a;
   endfunction

   always @(posedge clk) begin
      bit line;
      if (!rst_n) begin
         m_st = 0; m_c = 0; m_p = 0; m_l = 0; m_h = 0; m_hd = 0; m_su = 0;
         for (int i = 0; i < SYNC; i++) m_sy[i] = 1'b0;
      end else begin
         line = !(m_st == 1) && !stretch;
         if (!enable) begin
            m_st = 0; m_c = 0;
         end else begin
            case (m_st)
               0: if (run) begin m_st = 1; m_c = 0; end
               1: if (m_c + 1 == low_len() * (m_p + 1)) begin m_st = 2; m_c = 0; end
                  else m_c++;
               2: if (m_sy[SYNC-1]) begin m_st = 3; m_c = 0; end
               default: if (m_c + 1 == (m_h + 1) * (m_p + 1)) begin
                     m_st = run ? 1 : 0; m_c = 0;
                  end else m_c++;
            endcase
         end
         for (int i = SYNC - 1; i > 0; i--) m_sy[i] = m_sy[i-1];
         m_sy[0] = line;
         if (cfg_we && !enable) begin
            m_p = cfg_presc; m_l = cfg_low; m_h = cfg_high; m_hd = cfg_hold; m_su = cfg_setup;
         end
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit e_low, e_tick, e_upd;
         string tl;
         e_low  = (m_st == 1);
         e_tick = (m_st == 1 || m_st == 3) && (((m_c + 1) % (m_p + 1)) == 0);
         e_upd  = (m_st == 1) && (m_c == m_hd * (m_p + 1));
         case (m_st)
            0: tl = "R9 scl_low idle";
            1: tl = "R3 R7 scl_low low-phase";
            2: tl = "R5 scl_low wait-high";
            default: tl = "R4 scl_low high-phase";
         endcase
         chk(tl, scl_low_o, e_low);
         chk("R2 tick", tick_o, e_tick);
         chk("R6 sda_update", sda_update_o, e_upd);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic set_cfg(input int p, input int l, input int h, input int hd, input int su);
      cfg_presc = 4'(p); cfg_low = 8'(l); cfg_high = 8'(h);
      cfg_hold = 4'(hd); cfg_setup = 4'(su);
      cfg_we = 1'b1;
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic wait_low_rise();
      int g = 0;
      do begin @(negedge clk); g++; end while (!scl_low_o && g < 5000);
   endtask

   task automatic measure_low(output int n, output int upd_at, output int upd_n);
      n = 0; upd_at = -1; upd_n = 0;
      wait_low_rise();
      while (scl_low_o && n < 5000) begin
         if (sda_update_o) begin upd_n++; upd_at = n; end
         n++;
         @(negedge clk);
      end
   endtask

   task automatic measure_high(output int n);
      n = 0;
      wait_low_rise();
      while (scl_low_o) @(negedge clk);
      while (!scl_low_o && n < 5000) begin n++; @(negedge clk); end
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      int n, ua, un;
      @(negedge clk);
      chk("R1 reset scl_low", scl_low_o, 1'b0);
      chk("R1 reset tick", tick_o, 1'b0);
      chk("R1 reset sda_update", sda_update_o, 1'b0);
      step(2);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 post-reset scl_low", scl_low_o, 1'b0);
      step(1);

      // basic period, presc=1 low=3 high=2 hold=1 setup=0
      set_cfg(1, 3, 2, 1, 0);
      enable = 1'b1; run = 1'b1;
      step(1);
      measure_low(n, ua, un);
      chk_int("R3 low length", n, 8);
      chk_int("R6 strobe offset", ua, 2);
      chk_int("R6 strobe count", un, 1);
      measure_low(n, ua, un);
      chk_int("R3 low length second period", n, 8);

      // write while enabled must be ignored
      step(1);
      set_cfg(0, 9, 9, 0, 0);
      measure_low(n, ua, un);
      chk_int("R8 low length unchanged", n, 8);

      // stop request
      step(1);
      run = 1'b0;
      step(60);
      @(negedge clk);
      chk("R9 idle after run cleared", scl_low_o, 1'b0);
      chk("R9 no tick when idle", tick_o, 1'b0);
      step(1);
      enable = 1'b0;
      step(2);

      // delays dominate: presc=0 low=0 hold=3 setup=4
      set_cfg(0, 0, 0, 3, 4);
      enable = 1'b1; run = 1'b1;
      measure_low(n, ua, un);
      chk_int("R7 stretched low length", n, 8);
      chk_int("R6 strobe offset hold=3", ua, 3);
      step(1);
      enable = 1'b0;
      step(2);

      // large prescaler
      set_cfg(15, 2, 0, 0, 0);
      enable = 1'b1;
      measure_low(n, ua, un);
      chk_int("R3 low length presc=15", n, 48);
      chk_int("R6 strobe at phase start", ua, 0);
      step(1);
      enable = 1'b0;
      step(2);

      // stretching and high time: presc=2 low=1 high=1
      set_cfg(2, 1, 1, 0, 0);
      enable = 1'b1;
      measure_high(n);
      chk_int("R4 release length", n, SYNC + 1 + 6);
      wait_low_rise();
      @(posedge clk); #2;
      stretch = 1'b1;
      do @(negedge clk); while (scl_low_o);
      for (int k = 0; k < 12; k++) begin
         chk("R5 held low: no drive", scl_low_o, 1'b0);
         chk("R5 held low: no tick", tick_o, 1'b0);
         @(negedge clk);
      end
      @(posedge clk); #2;
      stretch = 1'b0;
      measure_low(n, ua, un);
      chk_int("R3 low after stretch", n, 6);

      // disable in the middle of a low phase
      wait_low_rise();
      @(posedge clk); #2;
      enable = 1'b0;
      @(negedge clk);
      chk("R9 still low before edge", scl_low_o, 1'b1);
      @(negedge clk);
      chk("R9 released after disable", scl_low_o, 1'b0);
      step(5);
      finish_run();
   end
endmodule